// File: doc/BRIEF.md
# Tapped Segmented Shift Register

This block is a 64-stage serial shift register built from four equal segments of 16 stages. A tap sits after each segment and brings out the last stage of that segment (stages 16, 32, 48 and 64). A single mode input chooses between two behaviours. In the drive mode, the register is one long serial chain and every tap shows its stage. In the accept mode, every tap output is disabled. The three intermediate taps then turn into inputs, and each one feeds the first stage of the segment that follows it.

The accept mode lets a host fill all 64 stages in 16 clocks, because all four segments load at the same time. It also lets the taps share a bus with other drivers. The three-state tap is split into three synthesizable signals: an output value, an output enable, and a separate input value. A disabled tap drives its output value to zero. The serial input always enters stage 1 on each rising edge, whatever the mode. A synchronous active-high reset clears every stage.

Top module: `seg_shift_chain`

## Requirements
- R1: When `load_en` is 0, `tap_oe` is all ones and `tap_out[k]` equals the content of stage 16*(k+1): bit 0 is stage 16, bit 1 is stage 32, bit 2 is stage 48 and bit 3 is stage 64.
- R2: On every rising edge without reset, stage 1 takes the value of `ser_in`, whatever the value of `load_en`.
- R3: While `load_en` is 1, `tap_oe` is all zeros and every bit of `tap_out` reads 0, in the same cycle.
- R4: On an edge with `load_en` at 1, stage 16*(k+1)+1 takes `tap_in[k]` for k = 0, 1, 2 (stages 17, 33, 49), and the content of stages 16, 32 and 48 is not passed on.
- R5: On an edge with `load_en` at 0, stages 17, 33 and 49 take the previous content of stages 16, 32 and 48, and `tap_in` has no effect.
- R6: Every stage that does not start a segment takes the previous content of the stage before it on each rising edge. Stored data changes only on the rising edge.
- R7: An edge with `rst` at 1 clears all 64 stages to 0, so the taps read 0 in drive mode after that edge.
- R8: Sixteen edges in accept mode, followed by serial shifting in drive mode, bring the loaded data out of the stage-64 tap in this order: first the segment-4 inputs from load clocks 1 to 16, then the segment-3 inputs, then segment 2, then the `ser_in` values of the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | 1 = accept mode (taps are inputs), 0 = drive mode |
| ser_in | input | 1 | Serial data into stage 1 |
| tap_in | input | 3 | Values for stages 17, 33 and 49 in accept mode |
| tap_out | output | 4 | Tap values for stages 16, 32, 48 and 64; zero when disabled |
| tap_oe | output | 4 | Tap output enables, high in drive mode |

## Verification
The tap enables and the zeroing of disabled taps follow `load_en` through logic alone, so they are due in the same cycle the mode changes. Stored data moves one stage per rising edge: a value driven on `ser_in` or `tap_in` reaches the next tap 16 edges later. The bench drives its inputs, lets the edge pass, and compares every tap against a 64-entry behavioural array 1 ns after that edge. That is after the state has settled and before the next inputs are applied. The load-and-drain check samples the stage-64 tap once per shift. It drives the mode back to 0 before each sample, so the disabled output cannot hide a value.

// File: rtl/seg_chain_pkg.sv
package seg_chain_pkg;

    // Direction of the intermediate taps, selected by the mode input.
    typedef enum logic {
        TAP_DRIVE  = 1'b0,
        TAP_ACCEPT = 1'b1
    } tap_dir_e;

    function automatic tap_dir_e dir_from_mode(input logic load);
        return load ? TAP_ACCEPT : TAP_DRIVE;
    endfunction

endpackage

// File: rtl/seg_shift_lane.sv
module seg_shift_lane #(
    parameter int LEN = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           feed,
    output logic [LEN-1:0] bits
);

    typedef struct packed {
        logic [LEN-1:0] bits;
    } lane_t;

    lane_t st_d;
    lane_t st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.bits = '0;
        end else begin
            st_d.bits = {st_q.bits[LEN-2:0], feed};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign bits = st_q.bits;

endmodule

// File: rtl/seg_tap_ctrl.sv
module seg_tap_ctrl
    import seg_chain_pkg::*;
#(
    parameter int SEGS = 4
) (
    input  tap_dir_e          dir,
    input  logic              ser_in,
    input  logic [SEGS-1:0]   seg_last,
    input  logic [SEGS-2:0]   tap_in,
    output logic [SEGS-1:0]   seg_feed,
    output logic [SEGS-1:0]   tap_out,
    output logic [SEGS-1:0]   tap_oe
);

    typedef struct packed {
        logic [SEGS-1:0] feed;
        logic [SEGS-1:0] val;
        logic [SEGS-1:0] oe;
    } tap_t;

    tap_t tap_d;

    always_comb begin
        tap_d         = '0;
        tap_d.feed[0] = ser_in;
        for (int k = 1; k < SEGS; k++) begin
            tap_d.feed[k] = (dir == TAP_ACCEPT) ? tap_in[k-1] : seg_last[k-1];
        end
        for (int k = 0; k < SEGS; k++) begin
            tap_d.oe[k]  = (dir == TAP_DRIVE);
            tap_d.val[k] = (dir == TAP_DRIVE) ? seg_last[k] : 1'b0;
        end
    end

    assign seg_feed = tap_d.feed;
    assign tap_out  = tap_d.val;
    assign tap_oe   = tap_d.oe;

endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain
    import seg_chain_pkg::*;
#(
    parameter int SEG_LEN = 16,
    parameter int SEG_CNT = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load_en,
    input  logic               ser_in,
    input  logic [SEG_CNT-2:0] tap_in,
    output logic [SEG_CNT-1:0] tap_out,
    output logic [SEG_CNT-1:0] tap_oe
);

    localparam int TOTAL = SEG_LEN * SEG_CNT;

    tap_dir_e               dir;
    logic [SEG_CNT-1:0]     seg_feed;
    logic [SEG_CNT-1:0]     seg_last;
    logic [TOTAL-1:0]       chain_q;

    assign dir = dir_from_mode(load_en);

    for (genvar k = 0; k < SEG_CNT; k++) begin : g_lane
        logic [SEG_LEN-1:0] lane_bits;
        seg_shift_lane #(.LEN(SEG_LEN)) lane_i (
            .clk  (clk),
            .rst  (rst),
            .feed (seg_feed[k]),
            .bits (lane_bits)
        );
        assign chain_q[k*SEG_LEN +: SEG_LEN] = lane_bits;
        assign seg_last[k]                   = lane_bits[SEG_LEN-1];
    end

    seg_tap_ctrl #(.SEGS(SEG_CNT)) tap_i (
        .dir      (dir),
        .ser_in   (ser_in),
        .seg_last (seg_last),
        .tap_in   (tap_in),
        .seg_feed (seg_feed),
        .tap_out  (tap_out),
        .tap_oe   (tap_oe)
    );

endmodule

// File: rtl/seg_shift_chain_chk.sv
module seg_shift_chain_chk #(
    parameter int SEG_LEN = 16,
    parameter int SEG_CNT = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       load_en,
    input logic                       ser_in,
    input logic [SEG_CNT-2:0]         tap_in,
    input logic [SEG_CNT-1:0]         tap_out,
    input logic [SEG_CNT-1:0]         tap_oe,
    input logic [SEG_LEN*SEG_CNT-1:0] chain_q
);

    localparam int TOTAL = SEG_LEN * SEG_CNT;

    // R2
    ser_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> chain_q[0] == $past(ser_in));

    // R3
    tap_off_chk: assert property (@(posedge clk) disable iff (rst)
        load_en |-> (tap_oe == '0 && tap_out == '0));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> chain_q == '0);

    for (genvar k = 0; k < SEG_CNT; k++) begin : g_tap
        // R1
        tap_show_chk: assert property (@(posedge clk) disable iff (rst)
            !load_en |-> (tap_oe[k] && tap_out[k] == chain_q[k*SEG_LEN + SEG_LEN - 1]));
    end

    for (genvar k = 1; k < SEG_CNT; k++) begin : g_seam
        // R4
        seam_load_chk: assert property (@(posedge clk) disable iff (rst)
            load_en |=> chain_q[k*SEG_LEN] == $past(tap_in[k-1]));
        // R5
        seam_pass_chk: assert property (@(posedge clk) disable iff (rst)
            !load_en |=> chain_q[k*SEG_LEN] == $past(chain_q[k*SEG_LEN-1]));
    end

    for (genvar i = 1; i < TOTAL; i++) begin : g_inner
        if ((i % SEG_LEN) != 0) begin : g_mid
            // R6
            inner_shift_chk: assert property (@(posedge clk) disable iff (rst)
                !rst |=> chain_q[i] == $past(chain_q[i-1]));
        end
    end

endmodule

bind seg_shift_chain seg_shift_chain_chk #(
    .SEG_LEN (SEG_LEN),
    .SEG_CNT (SEG_CNT)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .ser_in  (ser_in),
    .tap_in  (tap_in),
    .tap_out (tap_out),
    .tap_oe  (tap_oe),
    .chain_q (chain_q)
);

// File: tb/seg_shift_chain_tb.sv
`timescale 1ns/1ps
module seg_shift_chain_tb_top;

    localparam int L = 16;
    localparam int S = 4;
    localparam int N = L * S;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [S-2:0] tap_in = '0;
    logic [S-1:0] tap_out;
    logic [S-1:0] tap_oe;

    int total = 0;
    int bad   = 0;

    logic mdl [1:N];
    logic loadv [0:S-1][0:L-1];

    always #2 clk = ~clk;

    seg_shift_chain #(.SEG_LEN(L), .SEG_CNT(S)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .load_en (load_en),
        .ser_in  (ser_in),
        .tap_in  (tap_in),
        .tap_out (tap_out),
        .tap_oe  (tap_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 1; i <= N; i++) mdl[i] = 1'b0;
        end else begin
            for (int i = N; i >= 2; i--) begin
                if ((i - 1) % L == 0)
                    mdl[i] = load_en ? tap_in[(i-1)/L - 1] : mdl[i-1];
                else
                    mdl[i] = mdl[i-1];
            end
            mdl[1] = ser_in;
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < S; k++) begin
            if (load_en) begin
                chk(tap_oe[k] == 1'b0 && tap_out[k] == 1'b0, "R3 disabled tap",
                    {tap_oe[k], tap_out[k]}, 0);
            end else begin
                chk(tap_oe[k] == 1'b1, "R1 tap enable", tap_oe[k], 1);
                chk(tap_out[k] == mdl[L*(k+1)], "R1/R2/R4/R5/R6 tap value",
                    tap_out[k], mdl[L*(k+1)]);
            end
        end
    endtask

    task automatic step(input logic ld, input logic s, input logic [S-2:0] ti);
        load_en = ld;
        ser_in  = s;
        tap_in  = ti;
        @(posedge clk);
        model_edge();
        #1;
        compare_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 1; i <= N; i++) mdl[i] = 1'b0;

        // R7: reset state
        rst = 1'b1;
        repeat (3) step(1'b0, 1'b1, '1);
        chk(tap_out == '0, "R7 reset clears taps", tap_out, 0);
        chk(tap_oe == '1, "R1 enables after reset", tap_oe, 15);
        rst = 1'b0;

        // R2/R5/R6: serial shifting; R5 tap_in ignored in drive mode
        for (int c = 0; c < 80; c++) step(1'b0, 1'(c % 3 == 0), 3'($urandom));
        for (int c = 0; c < 70; c++) step(1'b0, 1'($urandom), '1);

        // R3 same-cycle disable when the mode rises
        load_en = 1'b1;
        #1;
        chk(tap_oe == '0 && tap_out == '0, "R3 immediate disable", {tap_oe, tap_out}, 0);

        // R8: 16-clock parallel load, then 64-clock drain through stage 64
        rst = 1'b1;
        step(1'b0, 1'b0, '0);
        rst = 1'b0;
        for (int c = 0; c < L; c++) begin
            logic s;
            logic [S-2:0] ti;
            s  = 1'($urandom);
            ti = 3'($urandom) ^ 3'(c);
            loadv[0][c] = s;
            for (int k = 1; k < S; k++) loadv[k][c] = ti[k-1];
            step(1'b1, s, ti);
        end
        for (int n = 0; n < N; n++) begin
            logic exp;
            exp = loadv[S-1 - n/L][n%L];
            load_en = 1'b0;
            #1;
            chk(tap_out[S-1] == exp, "R8 drain order", tap_out[S-1], exp);
            step(1'b0, 1'b0, '0);
        end

        // Mixed modes (R2/R4/R5/R6 against the model)
        for (int c = 0; c < 300; c++) step(1'($urandom % 4 == 0), 1'($urandom), 3'($urandom));

        // R7: reset in the middle of traffic
        for (int c = 0; c < 20; c++) step(1'b0, 1'b1, '0);
        rst = 1'b1;
        step(1'b0, 1'b1, '1);
        rst = 1'b0;
        chk(tap_out == '0, "R7 mid-run reset", tap_out, 0);
        for (int c = 0; c < 40; c++) step(1'b0, 1'($urandom), '0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule